// File: doc/BRIEF.md
# Dual-Reload PWM Down Timer

An 8-bit down-counter that steps on a selectable count tick and reloads itself automatically every time it underflows. Two reload values are held side by side: a low-phase value and a high-phase value. With the waveform output enabled, the reloads alternate between the two values and the output flip-flop toggles on every underflow. The low-phase value therefore sets how long the output stays low and the high-phase value sets how long it stays high. With the waveform output disabled, only the low-phase value is used and the output stays low, so the block acts as a plain periodic timer.

Counting is paced by single-cycle tick pulses. The tick comes either from the oscillator or from a prescaler, and a divide-by-2 stage can be inserted after the selection. Each underflow sets a sticky interrupt request flag, which is cleared by a strobe. Software-facing access is limited to write strobes: one for the configuration, one for each reload value, and one to clear the flag.

Top module: `dpt_timer`

## Requirements
- R1: While reset is high, and after it is released with no writes, the count is 0, the waveform output is 0 and the flag is 0.
- R2: A configuration write that sets the run bit (bit 0) while the timer is stopped loads the count from the low-phase value and drives the output low. A configuration write made while the timer is already running does not reload the count.
- R3: While running, each count step lowers a nonzero count by one. A step taken at count 0 is an underflow, and that step reloads the count. With no step, or while stopped, the count holds.
- R4: With the output-enable bit (bit 3) at 0, every underflow reloads from the low-phase value. The output is low from one clock after the write that cleared the bit.
- R5: With the output-enable bit at 1, underflows reload from the high-phase value and the low-phase value in turn, starting with the high-phase value after a start. The output toggles at each underflow, so it stays low for low-phase+1 steps and high for high-phase+1 steps.
- R6: The source bit (bit 1) selects the oscillator tick when 0 and the prescaler tick when 1. The unselected tick has no effect on the count.
- R7: With the divide bit (bit 2) set, a step occurs only on every second selected tick. After any configuration write, the first step falls on the second selected tick.
- R8: Each underflow sets the flag. The flag stays set until a clear strobe arrives. When an underflow and a clear arrive in the same cycle, the flag ends up set.
- R9: Writing a reload value never changes the count in progress. The new value is used at the next reload that selects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | Oscillator count tick, one cycle wide |
| pre_tick | input | 1 | Prescaler count tick, one cycle wide |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | {out_en, div2, src_pre, run} |
| lo_wr | input | 1 | Low-phase reload write strobe |
| hi_wr | input | 1 | High-phase reload write strobe |
| reload_wdata | input | 8 | Reload value to write |
| flag_clr | input | 1 | Interrupt flag clear strobe |
| cnt_q | output | 8 | Current count |
| pwm_out | output | 1 | Waveform output |
| irq_flag | output | 1 | Underflow interrupt request flag |

## Verification
The bench changes a reload value part-way through a count. A design that copies the new value straight into the counter would show a jump in the count instead of the expected decrement. It clears the flag in the same cycle as an underflow, which catches a clear that wrongly takes priority over the set. It feeds the unselected tick source and, with the divider on, checks both the odd and even ticks, which exposes a swapped source or a divider that starts in the wrong phase. It also clears the output-enable bit while the output is high. A design that forgot to force the output low there, or kept alternating the reloads, would leave the output high or reload from the high-phase value.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
  localparam int CFG_W = 4;
  // Field positions inside the configuration word
  localparam int CFG_RUN = 0;
  localparam int CFG_SRC = 1;
  localparam int CFG_DIV = 2;
  localparam int CFG_OUT = 3;

  typedef struct packed {
    logic out_en;   // bit 3
    logic div2;     // bit 2
    logic src_pre;  // bit 1
    logic run;      // bit 0
  } dpt_cfg_t;
endpackage

// File: rtl/dpt_tick_gen.sv
module dpt_tick_gen (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  input  logic src_pre,
  input  logic div2,
  input  logic osc_tick,
  input  logic pre_tick,
  output logic step
);
  logic src_tick;
  logic half_q;

  assign src_tick = src_pre ? pre_tick : osc_tick;
  assign step     = run && src_tick && (!div2 || half_q);

  always_ff @(posedge clk) begin
    if (rst || restart) half_q <= 1'b0;
    else if (run && src_tick && div2) half_q <= ~half_q;
  end

  // R7: with the divider active, a step is never followed by another step
  p_div_gap_r7: assert property (@(posedge clk) disable iff (rst)
    (step && div2 && !restart) |=> !step);
  // R6: with the oscillator selected, a step needs an oscillator tick
  p_src_osc_r6: assert property (@(posedge clk) disable iff (rst)
    (!src_pre && !osc_tick) |-> !step);
  // R6: with the prescaler selected, a step needs a prescaler tick
  p_src_pre_r6: assert property (@(posedge clk) disable iff (rst)
    (src_pre && !pre_tick) |-> !step);
endmodule

// File: rtl/dpt_counter.sv
module dpt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         step,
  input  logic         out_en,
  input  logic [W-1:0] lo_val,
  input  logic [W-1:0] hi_val,
  output logic [W-1:0] cnt_q,
  output logic         pwm_q,
  output logic         uf
);
  logic [W-1:0] reload_val;

  assign uf         = step && (cnt_q == '0);
  assign reload_val = (out_en && !pwm_q) ? hi_val : lo_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      pwm_q <= 1'b0;
    end else if (start) begin
      cnt_q <= lo_val;
      pwm_q <= 1'b0;
    end else if (uf) begin
      cnt_q <= reload_val;
      pwm_q <= out_en & ~pwm_q;
    end else begin
      if (step) cnt_q <= cnt_q - 1'b1;
      if (!out_en) pwm_q <= 1'b0;
    end
  end

  // R2: a start loads the low-phase value and enters the low phase
  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> (cnt_q == $past(lo_val)) && !pwm_q);
  // R3: a step from a nonzero count decrements by one
  p_dec_r3: assert property (@(posedge clk) disable iff (rst)
    (step && cnt_q != '0 && !start) |=> cnt_q == W'($past(cnt_q) - 1'b1));
  // R3: without a step the count holds
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!step && !start) |=> $stable(cnt_q));
  // R4: output disabled means low-phase reload and a low output
  p_lo_only_r4: assert property (@(posedge clk) disable iff (rst)
    (uf && !out_en) |=> (cnt_q == $past(lo_val)) && !pwm_q);
  p_pwm_low_r4: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> !pwm_q);
  // R5: an underflow at the end of the low phase reloads high and raises the output
  p_alt_hi_r5: assert property (@(posedge clk) disable iff (rst)
    (uf && out_en && !pwm_q) |=> pwm_q && (cnt_q == $past(hi_val)));
  // R5: an underflow at the end of the high phase reloads low and drops the output
  p_alt_lo_r5: assert property (@(posedge clk) disable iff (rst)
    (uf && out_en && pwm_q) |=> !pwm_q && (cnt_q == $past(lo_val)));
endmodule

// File: rtl/dpt_flag.sv
module dpt_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  // R8: set wins, clear works alone, otherwise hold
  p_set_r8: assert property (@(posedge clk) disable iff (rst) set |=> flag_q);
  p_clr_r8: assert property (@(posedge clk) disable iff (rst) (clr && !set) |=> !flag_q);
  p_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (!set && !clr) |=> $stable(flag_q));
endmodule

// File: rtl/dpt_timer.sv
module dpt_timer
  import dpt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             osc_tick,
  input  logic             pre_tick,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             lo_wr,
  input  logic             hi_wr,
  input  logic [W-1:0]     reload_wdata,
  input  logic             flag_clr,
  output logic [W-1:0]     cnt_q,
  output logic             pwm_out,
  output logic             irq_flag
);
  dpt_cfg_t     cfg_q;
  dpt_cfg_t     cfg_new;
  logic [W-1:0] lo_q;
  logic [W-1:0] hi_q;
  logic         start;
  logic         step;
  logic         uf;

  assign cfg_new = dpt_cfg_t'(cfg_wdata);
  assign start   = cfg_wr && cfg_new.run && !cfg_q.run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else begin
      if (cfg_wr) cfg_q <= cfg_new;
      if (lo_wr)  lo_q  <= reload_wdata;
      if (hi_wr)  hi_q  <= reload_wdata;
    end
  end

  dpt_tick_gen u_tick (
    .clk      (clk),
    .rst      (rst),
    .restart  (cfg_wr),
    .run      (cfg_q.run),
    .src_pre  (cfg_q.src_pre),
    .div2     (cfg_q.div2),
    .osc_tick (osc_tick),
    .pre_tick (pre_tick),
    .step     (step)
  );

  dpt_counter #(.W(W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .step   (step),
    .out_en (cfg_q.out_en),
    .lo_val (lo_q),
    .hi_val (hi_q),
    .cnt_q  (cnt_q),
    .pwm_q  (pwm_out),
    .uf     (uf)
  );

  dpt_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .set    (uf),
    .clr    (flag_clr),
    .flag_q (irq_flag)
  );

  // R1: reset clears the visible state
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (cnt_q == '0) && !pwm_out && !irq_flag);
  // R3: a stopped timer never counts
  p_stopped_r3: assert property (@(posedge clk) disable iff (rst)
    !cfg_q.run |-> !step);
endmodule

// File: tb/tb_dpt_timer.sv
module tb_dpt_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_tick = 1'b0, pre_tick = 1'b0;
  logic       cfg_wr = 1'b0, lo_wr = 1'b0, hi_wr = 1'b0, flag_clr = 1'b0;
  logic [3:0] cfg_wdata = '0;
  logic [7:0] reload_wdata = '0;
  logic [7:0] cnt_q;
  logic       pwm_out, irq_flag;

  typedef struct {
    logic [7:0] c;
    logic       p;
    logic       f;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  dpt_timer dut (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .pre_tick(pre_tick),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .lo_wr(lo_wr), .hi_wr(hi_wr),
    .reload_wdata(reload_wdata), .flag_clr(flag_clr),
    .cnt_q(cnt_q), .pwm_out(pwm_out), .irq_flag(irq_flag)
  );

  // Driver: one cycle of stimulus, strobes cleared unless set by the caller
  task automatic cyc(input logic o, input logic p);
    @(negedge clk);
    cfg_wr = 1'b0; lo_wr = 1'b0; hi_wr = 1'b0; flag_clr = 1'b0;
    osc_tick = o; pre_tick = p;
  endtask

  task automatic wr_cfg(input logic [3:0] d);
    cyc(1'b0, 1'b0); cfg_wr = 1'b1; cfg_wdata = d;
  endtask

  task automatic wr_lo(input logic [7:0] v);
    cyc(1'b0, 1'b0); lo_wr = 1'b1; reload_wdata = v;
  endtask

  task automatic wr_hi(input logic [7:0] v);
    cyc(1'b0, 1'b0); hi_wr = 1'b1; reload_wdata = v;
  endtask

  task automatic clr_cyc(input logic o);
    cyc(o, 1'b0); flag_clr = 1'b1;
  endtask

  // Expected outputs after the clock edge that follows the stimulus just driven
  task automatic exp(input logic [7:0] c, input logic p, input logic f, input string tag);
    exp_t e;
    e.c = c; e.p = p; e.f = f; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compares queued items shortly after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (cnt_q !== e.c || pwm_out !== e.p || irq_flag !== e.f) begin
          failures++;
          $display("FAIL %s: cnt=%0d pwm=%0b flag=%0b expected cnt=%0d pwm=%0b flag=%0b",
                   e.tag, cnt_q, pwm_out, irq_flag, e.c, e.p, e.f);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset
    cyc(0, 0); cyc(0, 0); cyc(0, 0);
    exp(8'd0, 0, 0, "R1 during reset");
    cyc(0, 0); rst = 1'b0;
    exp(8'd0, 0, 0, "R1 after release");

    wr_lo(8'd3); wr_hi(8'd1);
    exp(8'd0, 0, 0, "R9 write while stopped");

    // R2 start, oscillator source, output disabled
    wr_cfg(4'b0001); exp(8'd3, 0, 0, "R2 start loads low value");
    cyc(1, 0); exp(8'd2, 0, 0, "R3 dec");
    cyc(1, 0); exp(8'd1, 0, 0, "R3 dec");
    cyc(1, 0); exp(8'd0, 0, 0, "R3 dec to zero");
    cyc(0, 1); exp(8'd0, 0, 0, "R6 prescaler tick ignored");
    cyc(0, 0); exp(8'd0, 0, 0, "R3 hold without tick");
    cyc(1, 0); exp(8'd3, 0, 1, "R4 reload low, R8 flag set");
    clr_cyc(0); exp(8'd3, 0, 0, "R8 clear");

    // R9 reload write mid-count
    cyc(1, 0); exp(8'd2, 0, 0, "R3 dec");
    wr_lo(8'd5); exp(8'd2, 0, 0, "R9 write keeps count");
    cyc(1, 0); exp(8'd1, 0, 0, "R3 dec");
    cyc(1, 0); exp(8'd0, 0, 0, "R3 dec");
    cyc(1, 0); exp(8'd5, 0, 1, "R9 new low value used");
    clr_cyc(0); exp(8'd5, 0, 0, "R8 clear");
    for (int i = 4; i >= 0; i--) begin
      cyc(1, 0); exp(8'(i), 0, 0, "R3 countdown");
    end
    clr_cyc(1); exp(8'd5, 0, 1, "R8 set wins over clear");

    // R2 rewrite while running, R6 prescaler, R7 divider
    wr_cfg(4'b0001); exp(8'd5, 0, 1, "R2 no reload while running");
    wr_cfg(4'b0011); exp(8'd5, 0, 1, "R6 switch source");
    cyc(1, 0); exp(8'd5, 0, 1, "R6 oscillator tick ignored");
    cyc(0, 1); exp(8'd4, 0, 1, "R6 prescaler step");
    wr_cfg(4'b0111); exp(8'd4, 0, 1, "R7 divider on");
    cyc(0, 1); exp(8'd4, 0, 1, "R7 first tick no step");
    cyc(0, 1); exp(8'd3, 0, 1, "R7 second tick steps");
    cyc(0, 0); exp(8'd3, 0, 1, "R7 idle");
    cyc(0, 1); exp(8'd3, 0, 1, "R7 odd tick no step");
    cyc(0, 1); exp(8'd2, 0, 1, "R7 even tick steps");
    wr_cfg(4'b0000); exp(8'd2, 0, 1, "R3 stop");
    cyc(1, 0); exp(8'd2, 0, 1, "R3 stopped holds");
    cyc(0, 1); exp(8'd2, 0, 1, "R3 stopped holds");

    // R5 waveform mode
    clr_cyc(0); exp(8'd2, 0, 0, "R8 clear");
    wr_lo(8'd2); wr_hi(8'd1);
    wr_cfg(4'b1001); exp(8'd2, 0, 0, "R2 start low phase");
    cyc(1, 0); exp(8'd1, 0, 0, "R5 low phase");
    cyc(1, 0); exp(8'd0, 0, 0, "R5 low phase");
    cyc(1, 0); exp(8'd1, 1, 1, "R5 reload high, output high");
    cyc(1, 0); exp(8'd0, 1, 1, "R5 high phase");
    cyc(1, 0); exp(8'd2, 0, 1, "R5 reload low, output low");
    cyc(1, 0); exp(8'd1, 0, 1, "R5 low phase");
    cyc(1, 0); exp(8'd0, 0, 1, "R5 low phase");
    cyc(1, 0); exp(8'd1, 1, 1, "R5 second high phase");

    // R4 disable while high
    wr_cfg(4'b0001); exp(8'd1, 1, 1, "R4 write edge");
    cyc(0, 0); exp(8'd1, 0, 1, "R4 output forced low");
    cyc(1, 0); exp(8'd0, 0, 1, "R3 dec");
    cyc(1, 0); exp(8'd2, 0, 1, "R4 reload from low only");

    cyc(0, 0); cyc(0, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule